// File: doc/BRIEF.md
# No-Write-Recovery Cycle Inserter

This stage sits between a March sequence generator and an SRAM test port. It takes one memory operation at a time over a valid/ready handshake and issues it to the memory as a registered command. When the test-mode input is high, every write is expanded into two back-to-back memory cycles. The first writes the bitwise complement of the data to the same address with bitline precharge turned off. The second is the ordinary write. Reads always pass straight through.

Expanding a write this way stresses the cell at full clock rate, the way a long pause would, so a retention test needs no idle wait. The cost is exactly one extra cycle per write. While the inserted cycle is on the bus, the stage drops its ready output, so the generator stalls for that one cycle and no operation is dropped or reordered. With test mode low the stage adds no cycles and changes no operation.

Top module: `nwr_inserter`

## Requirements
- R1: When a write is accepted with test_mode high, the next cycle shows mem_en=1, mem_we=1, mem_pc_off=1, the same address and the bitwise complement of the data. The cycle after that shows mem_en=1, mem_we=1, mem_pc_off=0, the same address and the original data.
- R2: mem_pc_off is high only during an inserted complementary write. It is never high on a read, on a real write, or on an idle cycle.
- R3: An accepted read (in_write=0) appears in the next cycle with mem_en=1, mem_we=0, mem_pc_off=0 and the same address, whatever the state of test_mode.
- R4: When a write is accepted with test_mode low, it appears in the next cycle as one memory write with its own data and mem_pc_off=0. No cycle is added.
- R5: in_ready is low for exactly the cycle in which an inserted write is on the bus, and high otherwise. Operations reach the memory in the order they were accepted, and none is lost.
- R6: test_mode is sampled only when an operation is accepted. A change of test_mode while an inserted write is on the bus does not affect the real write that follows it.
- R7: A cycle with no accepted operation, and no pending real write, gives mem_en=0, mem_we=0 and mem_pc_off=0 in the next cycle.
- R8: While rst_n is low, mem_en=0, mem_we=0, mem_pc_off=0 and in_ready=1.
- R9: In test mode, the back-to-back stream write-1, read becomes three consecutive memory cycles: complementary write 0 with precharge off, then write 1, then read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | Enables insertion of no-recovery writes |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The stage can accept an operation this cycle |
| in_write | input | 1 | 1 = write, 0 = read |
| in_addr | input | ADDR_W | Operation address |
| in_data | input | DATA_W | Write data |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_data | output | DATA_W | Memory write data |
| mem_pc_off | output | 1 | Bitline precharge disable for this cycle |

## Verification
The assertions assume the memory accepts a command on every cycle, since the stage has no backpressure from that side. They also assume that the inputs only matter in a cycle where in_valid and in_ready are both high. The stimulus respects both conditions. It changes inputs only between clock edges, and it holds each offered operation until it sees in_ready high. This includes the case where test_mode is toggled during a stall, which is meant to show that the pending real write is unaffected.

// File: rtl/nwr_inserter.sv
module nwr_inserter #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              mem_pc_off
);

  logic              pend;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic              take;

  assign take     = in_valid && in_ready;
  assign in_ready = !pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      mem_en     <= 1'b0;
      mem_we     <= 1'b0;
      mem_pc_off <= 1'b0;
      mem_addr   <= '0;
      mem_data   <= '0;
      hold_addr  <= '0;
      hold_data  <= '0;
    end else if (pend) begin
      pend       <= 1'b0;
      mem_en     <= 1'b1;
      mem_we     <= 1'b1;
      mem_pc_off <= 1'b0;
      mem_addr   <= hold_addr;
      mem_data   <= hold_data;
    end else if (take) begin
      mem_en    <= 1'b1;
      mem_we    <= in_write;
      mem_addr  <= in_addr;
      hold_addr <= in_addr;
      hold_data <= in_data;
      if (in_write && test_mode) begin
        pend       <= 1'b1;
        mem_pc_off <= 1'b1;
        mem_data   <= ~in_data;
      end else begin
        mem_pc_off <= 1'b0;
        mem_data   <= in_data;
      end
    end else begin
      mem_en     <= 1'b0;
      mem_we     <= 1'b0;
      mem_pc_off <= 1'b0;
    end
  end

  p_nw_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_write && test_mode |=> mem_en && mem_we && mem_pc_off &&
      mem_addr == $past(in_addr) && mem_data == ~$past(in_data));

  p_real_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_pc_off |=> mem_en && mem_we && !mem_pc_off &&
      mem_addr == $past(mem_addr) && mem_data == ~$past(mem_data));

  p_pc_off_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_pc_off |-> mem_en && mem_we);

  p_read_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && !in_write |=> mem_en && !mem_we && !mem_pc_off &&
      mem_addr == $past(in_addr));

  p_plain_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_write && !test_mode |=> mem_en && mem_we && !mem_pc_off &&
      mem_data == $past(in_data));

  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_pc_off |-> !in_ready);

  p_ready_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !take && in_ready |=> !mem_en && !mem_we && !mem_pc_off);

endmodule

// File: tb/nwr_inserter_test.sv
`timescale 1ns/1ps
module nwr_inserter_test;
  localparam int AW = 10;
  localparam int DW = 16;

  typedef struct {
    bit          en;
    bit          we;
    bit          pc;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string       tag;
  } cmd_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b0;
  logic in_valid = 1'b0;
  logic in_write = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, mem_en, mem_we, mem_pc_off;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  nwr_inserter #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_write(in_write), .in_addr(in_addr), .in_data(in_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_pc_off(mem_pc_off));

  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  bit checking = 0;
  string phase_tag = "";

  cmd_t q[$];
  cmd_t cur = '{0, 0, 0, '0, '0, "R8"};
  bit exp_ready = 1;

  function automatic cmd_t mk(bit en, bit we, bit pc, logic [AW-1:0] a,
                              logic [DW-1:0] d, string t);
    cmd_t c;
    c.en = en; c.we = we; c.pc = pc; c.addr = a; c.data = d;
    c.tag = (phase_tag != "") ? phase_tag : t;
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = '{0, 0, 0, '0, '0, "R8"};
      exp_ready = 1;
    end else begin
      if (in_valid && exp_ready) begin
        if (in_write && test_mode) begin
          q.push_back(mk(1, 1, 1, in_addr, ~in_data, "R1"));
          q.push_back(mk(1, 1, 0, in_addr, in_data, "R1"));
        end else begin
          q.push_back(mk(1, in_write, 0, in_addr, in_data, in_write ? "R4" : "R3"));
        end
      end
      if (q.size() > 0) cur = q.pop_front();
      else cur = '{0, 0, 0, '0, '0, "R7"};
      exp_ready = (q.size() == 0);
    end
  end

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking && !finished) begin
      chk(mem_en === cur.en, cur.tag, "mem_en", 64'(mem_en), 64'(cur.en));
      chk(mem_we === cur.we, cur.tag, "mem_we", 64'(mem_we), 64'(cur.we));
      chk(mem_pc_off === cur.pc, (cur.tag == "R8") ? "R8" : "R2", "mem_pc_off",
          64'(mem_pc_off), 64'(cur.pc));
      chk(in_ready === exp_ready, (cur.tag == "R8") ? "R8" : "R5", "in_ready",
          64'(in_ready), 64'(exp_ready));
      if (cur.en) begin
        chk(mem_addr === cur.addr, cur.tag, "mem_addr", 64'(mem_addr), 64'(cur.addr));
        if (cur.we)
          chk(mem_data === cur.data, cur.tag, "mem_data", 64'(mem_data), 64'(cur.data));
      end
    end
  end

  task automatic op(bit w, logic [AW-1:0] a, logic [DW-1:0] d, bit m);
    in_valid = 1; in_write = w; in_addr = a; in_data = d; test_mode = m;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    checking = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R9: W1 then R back to back in test mode
    phase_tag = "R9";
    op(1, 10'd5, 16'h0001, 1);
    op(0, 10'd5, 16'h0000, 1);
    idle(3);
    // R6: mode drops during inserted cycle; pending real write unaffected
    phase_tag = "R6";
    in_valid = 1; in_write = 1; in_addr = 10'd9; in_data = 16'hA5C3; test_mode = 1;
    @(negedge clk);
    test_mode = 0; in_addr = 10'd10; in_data = 16'h1234;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    idle(2);
    phase_tag = "";
    // R4 / R3: normal mode stream
    op(1, 10'd1, 16'hFFFF, 0);
    op(0, 10'd1, 16'h0000, 0);
    op(1, 10'd2, 16'h0000, 0);
    idle(2);
    // R1 / R3: test mode writes and reads with zero and all-ones data
    op(1, 10'd1023, 16'h0000, 1);
    op(1, 10'd0, 16'hFFFF, 1);
    op(0, 10'd0, 16'h0000, 1);
    idle(1);
    // mixed stream with gaps
    for (int i = 0; i < 600; i++) begin
      op($urandom_range(0, 1), AW'($urandom), DW'($urandom), $urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(4);
    // R8: reset mid-stream
    in_valid = 1; in_write = 1; test_mode = 1;
    @(negedge clk);
    rst_n = 0;
    in_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(3);
    summary();
  end
endmodule